// File: doc/BRIEF.md
# Multi-channel DMA start scheduler

This block decides when each of seven DMA channels may begin a transfer. Software programs every channel through a single write port, using three kinds of word. A per-channel control word holds the busy flag, the sync mode and the manual start trigger. A per-channel block word holds the block size and the block count. A global word holds the channel enables and the interrupt enables, and it also clears interrupt flags. The separate transfer engine supplies a peripheral request input and a done pulse for each channel.

When a channel is queued and it meets the eligibility rules, the block loads a countdown with that channel's start delay. When the countdown reaches zero, the block issues a one-cycle start strobe, and then waits for the engine's done pulse. The done pulse ends the transfer: it clears the channel's busy flag and can raise the channel's interrupt flag. The smallest nonzero countdown is exported, so that a system timer can see the distance to the next event.

Top module: `dma_start_sched`

## Requirements
- R1: After a synchronous active-high reset, start_o, busy_o, irq_flag_o and irq_o are all zero, and min_ticks_o is all ones.
- R2: A control-word write (wr_kind 0) changes only the bits set in mask 0x71770703. Bit 24 is busy, bits 10:9 are sync mode (0 manual, 1 request/block, 2 linked list, 3 reserved) and bit 28 is the manual trigger. A write that sets only bits outside the mask leaves busy_o clear and starts nothing.
- R3: A channel is eligible only when its enable bit is set in the global word (wr_kind 2, bits 6:0), its busy bit is set, and, in manual sync mode, its trigger bit is set.
- R4: The start delay is 1 tick, except for channel 4 in request/block mode. For that case the delay is count × (size / 2), with count taken from block word bits 31:16 and size from bits 15:0 (wr_kind 1). For a delay D > 0, start_o pulses for one cycle exactly D+2 clock edges after the edge that captured the queuing write.
- R5: A computed delay of zero skips the countdown, and the start strobe follows 2 edges after the queuing write.
- R6: While a channel's countdown is nonzero, further queuing of that channel is ignored, and its start time does not move.
- R7: A control or block write queues only the addressed channel. A global write, or a rising edge on any req_i bit, queues every channel.
- R8: Channels that become due in the same cycle receive their start strobes in ascending index order, one per cycle.
- R9: A done pulse on a started channel clears its busy bit and its countdown, and it sets that channel's irq_flag_o bit if the channel's interrupt enable (global bits 22:16) is set. A done pulse on a channel that has not been started has no effect.
- R10: irq_o equals master enable (global bit 23) AND (irq_flag_o & interrupt enables) being nonzero. A global write with 1s in bits 30:24 clears those flags.
- R11: min_ticks_o equals the smallest nonzero countdown across channels, or all ones when no countdown is running.
- R12: A channel that is no longer eligible when its countdown expires does not start, and it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 control word, 1 block word, 2 global word |
| wr_chan | input | 3 | Target channel for control and block writes |
| wr_data | input | 32 | Write data |
| req_i | input | 7 | Peripheral request per channel |
| done_i | input | 7 | Transfer-complete pulse per channel |
| start_o | output | 7 | One-cycle start strobe per channel |
| busy_o | output | 7 | Busy bit of each channel's control word |
| irq_flag_o | output | 7 | Per-channel interrupt flags |
| irq_o | output | 1 | Master interrupt |
| min_ticks_o | output | 32 | Smallest pending countdown, all ones if none |

## Verification
Start arbitration and countdown expiry can coincide in the same cycle. Several channels that reach zero together must be served one per cycle, and no strobe may be lost. The bench provokes this by making three channels busy while they are disabled, and then enabling all of them with one global write, so that their countdowns expire on the same edge. Each channel's strobe cycle is then compared with the expected ascending sequence, at offsets 3, 4 and 5 from the global write. A second overlap is a queue attempt that lands while a countdown is running, from a rewrite or from a request edge. That case is judged by checking that the original start time is unchanged.

// File: rtl/dsch_pkg.sv
package dsch_pkg;

    localparam int NCH   = 7;
    localparam int CHW   = $clog2(NCH);
    localparam int CNT_W = 32;

    localparam logic [31:0] CTRL_WMASK = 32'h7177_0703;
    localparam int BUSY_BIT = 24;
    localparam int TRIG_BIT = 28;
    localparam int SYNC_LSB = 9;

    typedef enum logic [1:0] {
        SYNC_MANUAL = 2'd0,
        SYNC_BLOCK  = 2'd1,
        SYNC_LIST   = 2'd2,
        SYNC_RSVD   = 2'd3
    } sync_e;

    typedef enum logic [1:0] {
        WK_CTRL   = 2'd0,
        WK_BLOCK  = 2'd1,
        WK_GLOBAL = 2'd2,
        WK_NONE   = 2'd3
    } wkind_e;

    typedef struct packed {
        logic [15:0] count;
        logic [15:0] size;
    } blk_t;

    typedef struct packed {
        logic           rsv_hi;
        logic [NCH-1:0] flag_clr;
        logic           master;
        logic [NCH-1:0] irq_en;
        logic [8:0]     rsv_mid;
        logic [NCH-1:0] chan_en;
    } glb_t;

    function automatic logic [31:0] ctrl_merge(input logic [31:0] old_w, input logic [31:0] new_w);
        return (old_w & ~CTRL_WMASK) | (new_w & CTRL_WMASK);
    endfunction

    function automatic logic [CNT_W-1:0] start_delay(input logic is_sound, input sync_e s, input blk_t b);
        if (is_sound && s == SYNC_BLOCK)
            return CNT_W'(b.count) * CNT_W'(b.size >> 1);
        return CNT_W'(1);
    endfunction

endpackage

// File: rtl/dsch_chan.sv
module dsch_chan
    import dsch_pkg::*;
#(
    parameter bit IS_SOUND = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic             blk_we,
    input  logic [31:0]      wdata,
    input  logic             chan_en,
    input  logic             irq_en,
    input  logic             queue,
    input  logic             grant,
    input  logic             done,
    input  logic             flag_clr,
    output logic             busy,
    output logic             ready,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    logic [31:0]      ctrl_q;
    blk_t             blk_q;
    logic [CNT_W-1:0] cnt_q;
    logic             due_q;
    logic             run_q;
    logic             flag_q;

    sync_e            sync;
    logic             base_ok;
    logic             can_queue;
    logic             finish;
    logic [CNT_W-1:0] dly;

    assign sync      = sync_e'(ctrl_q[SYNC_LSB +: 2]);
    assign base_ok   = chan_en && ctrl_q[BUSY_BIT] && (sync != SYNC_MANUAL || ctrl_q[TRIG_BIT]);
    assign can_queue = base_ok && (cnt_q == '0) && !due_q && !run_q;
    assign finish    = done && run_q;
    assign dly       = start_delay(IS_SOUND, sync, blk_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            blk_q  <= '0;
            cnt_q  <= '0;
            due_q  <= 1'b0;
            run_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_we)
                ctrl_q <= ctrl_merge(ctrl_q, wdata);
            if (blk_we)
                blk_q <= blk_t'(wdata);

            if (queue && can_queue) begin
                if (dly == '0)
                    due_q <= 1'b1;
                else
                    cnt_q <= dly;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1))
                    due_q <= 1'b1;
            end

            if (due_q) begin
                if (grant) begin
                    due_q <= 1'b0;
                    run_q <= 1'b1;
                end else if (!base_ok) begin
                    due_q <= 1'b0;
                end
            end

            if (finish) begin
                run_q            <= 1'b0;
                cnt_q            <= '0;
                ctrl_q[BUSY_BIT] <= 1'b0;
            end

            if (flag_clr)
                flag_q <= 1'b0;
            if (finish && irq_en)
                flag_q <= 1'b1;
        end
    end

    assign busy  = ctrl_q[BUSY_BIT];
    assign ready = due_q && base_ok;
    assign cnt   = cnt_q;
    assign flag  = flag_q;

endmodule

// File: rtl/dsch_pick.sv
module dsch_pick #(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_pick
        assign grant[i]     = req[i] && !blocked[i];
        assign blocked[i+1] = blocked[i] || req[i];
    end

endmodule

// File: rtl/dsch_min.sv
module dsch_min #(
    parameter int N = 7,
    parameter int W = 32
) (
    input  logic [N-1:0][W-1:0] cnt,
    output logic [W-1:0]        min_out
);

    logic [N:0][W-1:0] best;

    assign best[0] = '1;

    for (genvar i = 0; i < N; i++) begin : g_min
        assign best[i+1] = (cnt[i] != '0 && cnt[i] < best[i]) ? cnt[i] : best[i];
    end

    assign min_out = best[N];

endmodule

// File: rtl/dma_start_sched.sv
module dma_start_sched
    import dsch_pkg::*;
#(
    parameter int SOUND_CH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [CHW-1:0]   wr_chan,
    input  logic [31:0]      wr_data,
    input  logic [NCH-1:0]   req_i,
    input  logic [NCH-1:0]   done_i,
    output logic [NCH-1:0]   start_o,
    output logic [NCH-1:0]   busy_o,
    output logic [NCH-1:0]   irq_flag_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] min_ticks_o
);

    glb_t                      glb_q;
    glb_t                      glb_w;
    logic [NCH-1:0]            req_q;
    logic [NCH-1:0]            q_pend;
    logic [NCH-1:0]            q_nxt;
    logic [NCH-1:0]            ctrl_we;
    logic [NCH-1:0]            blk_we;
    logic [NCH-1:0]            ready;
    logic [NCH-1:0]            grant;
    logic [NCH-1:0]            start_q;
    logic [NCH-1:0]            flag_clr;
    logic [NCH-1:0][CNT_W-1:0] cnt;
    logic                      glb_we;
    logic                      req_rise;

    assign glb_w    = glb_t'(wr_data);
    assign glb_we   = wr_en && wkind_e'(wr_kind) == WK_GLOBAL;
    assign req_rise = |(req_i & ~req_q);
    assign flag_clr = glb_we ? glb_w.flag_clr : '0;
    assign q_nxt    = ctrl_we | blk_we | {NCH{glb_we || req_rise}};

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_q   <= '0;
            req_q   <= '0;
            q_pend  <= '0;
            start_q <= '0;
        end else begin
            if (glb_we) begin
                glb_q          <= glb_w;
                glb_q.flag_clr <= '0;
            end
            req_q   <= req_i;
            q_pend  <= q_nxt;
            start_q <= grant;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ctrl_we[c] = wr_en && wkind_e'(wr_kind) == WK_CTRL  && wr_chan == CHW'(c);
        assign blk_we[c]  = wr_en && wkind_e'(wr_kind) == WK_BLOCK && wr_chan == CHW'(c);

        dsch_chan #(
            .IS_SOUND(c == SOUND_CH)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ctrl_we (ctrl_we[c]),
            .blk_we  (blk_we[c]),
            .wdata   (wr_data),
            .chan_en (glb_q.chan_en[c]),
            .irq_en  (glb_q.irq_en[c]),
            .queue   (q_pend[c]),
            .grant   (grant[c]),
            .done    (done_i[c]),
            .flag_clr(flag_clr[c]),
            .busy    (busy_o[c]),
            .ready   (ready[c]),
            .cnt     (cnt[c]),
            .flag    (irq_flag_o[c])
        );
    end

    dsch_pick #(.N(NCH)) u_pick (
        .req  (ready),
        .grant(grant)
    );

    dsch_min #(.N(NCH), .W(CNT_W)) u_min (
        .cnt    (cnt),
        .min_out(min_ticks_o)
    );

    assign start_o = start_q;
    assign irq_o   = glb_q.master && ((irq_flag_o & glb_q.irq_en) != '0);

endmodule

// File: rtl/dsch_chk.sv
module dsch_chk
    import dsch_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] start,
    input logic [NCH-1:0] busy,
    input logic [NCH-1:0] flags,
    input logic           irq,
    input logic [NCH-1:0] done
);

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (busy == '0 && flags == '0 && start == '0));

    a_r8_one_start: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start));

    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        (start & $past(start)) == '0);

    a_r9_flag_from_done: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~$past(flags)) != '0) |-> ($past(done) != '0));

    a_r10_irq_has_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

endmodule

bind dma_start_sched dsch_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .start(start_o),
    .busy (busy_o),
    .flags(irq_flag_o),
    .irq  (irq_o),
    .done (done_i)
);

// File: tb/test_dma_start_sched.sv
`timescale 1ns/1ps
module test_dma_start_sched;

    localparam logic [31:0] BUSY = 32'h0100_0000;
    localparam logic [31:0] TRIG = 32'h1000_0000;
    localparam logic [31:0] SYN1 = 32'h0000_0200;
    localparam logic [31:0] GLB  = 32'h7FFF_007F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic [2:0]  wr_chan = 3'd0;
    logic [31:0] wr_data = '0;
    logic [6:0]  req_i = '0;
    logic [6:0]  done_i = '0;
    logic [6:0]  start_o, busy_o, irq_flag_o;
    logic        irq_o;
    logic [31:0] min_ticks_o;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int t_wr = 0;
    int last_st [7];
    int nst [7];

    always #10 clk = ~clk;

    dma_start_sched i_dma_start_sched (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_chan(wr_chan),
        .wr_data(wr_data), .req_i(req_i), .done_i(done_i), .start_o(start_o),
        .busy_o(busy_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o), .min_ticks_o(min_ticks_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int c = 0; c < 7; c++) begin
            if (start_o[c]) begin
                last_st[c] = cyc;
                nst[c]     = nst[c] + 1;
            end
        end
    end

    function automatic int exp_lat(input int d);
        return (d == 0) ? 2 : d + 2;
    endfunction

    function automatic int snd_delay(input int cnt, input int sz);
        return cnt * (sz / 2);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int ch, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_chan = 3'(ch); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        t_wr = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fin(input int ch);
        @(negedge clk);
        done_i[ch] = 1'b1;
        @(negedge clk);
        done_i = '0;
    endtask

    initial begin
        for (int c = 0; c < 7; c++) begin
            last_st[c] = 0;
            nst[c]     = 0;
        end
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int t0, s, d, c0, sz;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 flags", 32'(irq_flag_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 start", 32'(start_o), 0);
        chk("R1 min", min_ticks_o, 32'hFFFF_FFFF);

        wr(2'd2, 0, GLB);
        // R4 default delay 1, R11 min after load
        s = nst[0];
        wr(2'd0, 0, BUSY | SYN1); t0 = t_wr;
        chk("R3 busy set", 32'(busy_o[0]), 1);
        idle(1);
        chk("R11 min=1", min_ticks_o, 1);
        idle(5);
        chk("R4 one start", nst[0] - s, 1);
        chk("R4 latency", last_st[0] - t0, 3);
        fin(0);
        chk("R9 busy clr", 32'(busy_o[0]), 0);
        chk("R9 flag set", 32'(irq_flag_o[0]), 1);
        chk("R10 irq on", 32'(irq_o), 1);
        wr(2'd2, 0, GLB);
        chk("R10 flag cleared", 32'(irq_flag_o), 0);
        chk("R10 irq off", 32'(irq_o), 0);
        chk("R11 none", min_ticks_o, 32'hFFFF_FFFF);

        // R2 unmasked bits only
        s = nst[6];
        wr(2'd0, 6, 32'h8E88_F8FC);
        idle(6);
        chk("R2 busy", 32'(busy_o[6]), 0);
        chk("R2 no start", nst[6] - s, 0);

        // R3 manual needs trigger
        s = nst[2];
        wr(2'd0, 2, BUSY);
        idle(6);
        chk("R3 manual no trig", nst[2] - s, 0);
        wr(2'd0, 2, BUSY | TRIG); t0 = t_wr;
        idle(5);
        chk("R3 manual trig latency", last_st[2] - t0, 3);
        fin(2);

        // R4 sound channel delay + R11
        wr(2'd1, 4, {16'd3, 16'd8});
        s = nst[4];
        wr(2'd0, 4, BUSY | SYN1); t0 = t_wr;
        idle(1);
        chk("R11 min=12", min_ticks_o, 12);
        idle(18);
        chk("R4 sound latency", last_st[4] - t0, 14);
        chk("R4 sound once", nst[4] - s, 1);
        fin(4);

        // R6 pending not re-queued, R7 request edge does not reload
        wr(2'd1, 4, {16'd4, 16'd10});
        s = nst[4];
        wr(2'd0, 4, BUSY | SYN1); t0 = t_wr;
        idle(3);
        wr(2'd0, 4, BUSY | SYN1);
        chk("R11 min counting", min_ticks_o, 32'(20 - (t_wr - t0 - 1)));
        @(negedge clk); req_i = 7'h10;
        @(negedge clk); req_i = 7'h00;
        idle(25);
        chk("R6 start unchanged", last_st[4] - t0, 22);
        chk("R6 single start", nst[4] - s, 1);
        fin(4);

        // R5 zero delay
        wr(2'd1, 4, {16'd0, 16'd8});
        wr(2'd0, 4, BUSY | SYN1); t0 = t_wr;
        idle(4);
        chk("R5 zero delay", last_st[4] - t0, 2);
        fin(4);

        // R12 cancelled before expiry
        wr(2'd1, 4, {16'd4, 16'd10});
        s = nst[4];
        wr(2'd0, 4, BUSY | SYN1);
        idle(4);
        wr(2'd0, 4, SYN1);
        chk("R12 busy dropped", 32'(busy_o[4]), 0);
        idle(28);
        chk("R12 no start", nst[4] - s, 0);
        chk("R12 min idle", min_ticks_o, 32'hFFFF_FFFF);

        // R9 done ignored when not started, R7 global queues all
        wr(2'd2, 0, 32'h7FFF_0077);
        s = nst[3];
        wr(2'd0, 3, BUSY | SYN1);
        idle(6);
        chk("R3 disabled no start", nst[3] - s, 0);
        fin(3);
        chk("R9 ignored busy", 32'(busy_o[3]), 1);
        chk("R9 ignored flag", 32'(irq_flag_o[3]), 0);
        wr(2'd2, 0, GLB); t0 = t_wr;
        idle(5);
        chk("R7 global queues", last_st[3] - t0, 3);
        fin(3);
        chk("R9 flag3", 32'(irq_flag_o[3]), 1);

        // R8 simultaneous expiry, ascending order
        wr(2'd2, 0, 32'h7FFF_0000);
        wr(2'd0, 0, BUSY | SYN1);
        wr(2'd0, 2, BUSY | SYN1);
        wr(2'd0, 5, BUSY | SYN1);
        wr(2'd2, 0, GLB); t0 = t_wr;
        idle(8);
        chk("R8 ch0", last_st[0] - t0, 3);
        chk("R8 ch2", last_st[2] - t0, 4);
        chk("R8 ch5", last_st[5] - t0, 5);
        fin(0); fin(2); fin(5);

        // R9 irq enable off, R10 master off
        wr(2'd2, 0, 32'h7FFE_007F);
        wr(2'd0, 0, BUSY | SYN1);
        idle(5);
        fin(0);
        chk("R9 irq en off", 32'(irq_flag_o[0]), 0);
        wr(2'd2, 0, 32'h7F7F_007F);
        wr(2'd0, 1, BUSY | SYN1);
        idle(5);
        fin(1);
        chk("R10 flag w/o master", 32'(irq_flag_o[1]), 1);
        chk("R10 master off", 32'(irq_o), 0);
        wr(2'd2, 0, GLB);

        // R4 random sound delays
        for (int it = 0; it < 10; it++) begin
            c0 = int'($urandom_range(0, 4));
            sz = int'($urandom_range(0, 15));
            d  = snd_delay(c0, sz);
            wr(2'd1, 4, {16'(c0), 16'(sz)});
            s = nst[4];
            wr(2'd0, 4, BUSY | SYN1); t0 = t_wr;
            idle(d + 4);
            chk("R4 random latency", last_st[4] - t0, 32'(exp_lat(d)));
            chk("R4 random once", nst[4] - s, 1);
            fin(4);
        end

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule